// File: doc/BRIEF.md
# Neuron Coordinate Decode and Connection Field Unit

This block takes one active neuron at a time, named by a sector number and a block number, and turns it into layer coordinates X and Y. From those coordinates it works out the span of connected neurons in each dimension, as a first index and a last index. The span follows a connection rule chosen from a local table of 32 entries, indexed by a connection number that arrives with the neuron. Each entry holds an independent rule for X and for Y.

A rule is either divergent (one source neuron reaches a scaled, widened field) or convergent (many sources fold onto one target). A per-neuron direction flag selects the learning (backward) pass, which swaps the two kinds. All layer, block and scale sizes are powers of two, so every multiply, divide and modulo is a shift, a mask or a concatenation.

One shared datapath computes X first and then Y. The results are signed and are not clamped to the layer; a later stage does that. The input and the output each use a valid/ready handshake, with one transfer per neuron.

Top module: `conn_field_unit`

## Requirements
- R1: X equals (BN mod 2^BXL)·2^SXL + (SN mod 2^SXL); that is, the low BXL bits of the block number sit above the low SXL bits of the sector number.
- R2: Y equals (BN >> BXL)·2^SYL + (SN >> SXL).
- R3: A rule word is 20 bits: bit 19 is the convergent flag, bits 18:16 are the scale shift s (scale = 2^s), bits 15:8 are the unsigned overlap, and bits 7:0 are the two's-complement offset. For an effective divergent rule, first = C·2^s − overlap − offset and last = C·2^s + overlap + offset + 2^s − 1, where C is the coordinate.
- R4: For an effective convergent rule, first = floor(C/2^s) − overlap − offset and last = floor(C/2^s) + overlap + offset.
- R5: X uses only the X rule of the entry and Y uses only the Y rule, so the two dimensions can mix rule kinds.
- R6: When in_bwd is 1, the effective kind is the opposite of the stored convergent flag.
- R7: A cfg_we pulse writes both rules of entry cfg_idx. Each neuron uses the entry named by in_cn. A write to one entry leaves every other entry unchanged. After reset every entry reads as all zeros.
- R8: Results are signed FW-bit values that may be negative or beyond the layer, and they are passed out without clamping.
- R9: After an input handshake, in_ready stays low until the result is taken. out_valid rises on the third clock edge after the accepting edge. While out_ready is low, out_valid and all outputs hold steady. After the output handshake, out_valid falls.
- R10: out_cn returns the connection number of the neuron, and out_x and out_y return its decoded coordinates.
- R11: Out of reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the rule table |
| cfg_idx | input | IW | Table entry being written |
| cfg_rule_x | input | 20 | X rule word |
| cfg_rule_y | input | 20 | Y rule word |
| in_valid | input | 1 | Neuron offered |
| in_ready | output | 1 | Unit can take a neuron |
| in_sn | input | SXL+SYL | Sector number |
| in_bn | input | BXL+BYL | Block number |
| in_cn | input | IW | Connection number (table index) |
| in_bwd | input | 1 | Backward (learning) direction |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | BXL+SXL | Decoded X |
| out_y | output | BYL+SYL | Decoded Y |
| out_cn | output | IW | Connection number of the result |
| out_first_x | output | FW | First connected X (signed) |
| out_last_x | output | FW | Last connected X (signed) |
| out_first_y | output | FW | First connected Y (signed) |
| out_last_y | output | FW | Last connected Y (signed) |

## Verification
Neurons are swept over many sector and block numbers, which separates the bit-placement errors in the X and Y decode. Table entries pair divergent and convergent rules, with X and Y set differently, and with scales, overlaps and negative offsets chosen so that a swapped dimension, a missing scale−1 tail or a wrong shift gives a different field. The forward and backward flags alternate, which exposes a mode swap that does not happen. Entries placed near the origin drive first indices below zero to show that no clamping is applied. A consumer that stalls now and then tests that results are held.

// File: rtl/cfu_pkg.sv
// Shared types for the connection field unit: the per-dimension rule word
// and the sequencer states. Rule field widths are fixed here.
package cfu_pkg;
    localparam int SHW = 3;  // scale shift width (scale = 2**shift)
    localparam int OVW = 8;  // overlap width, unsigned
    localparam int OFW = 8;  // offset width, two's complement

    typedef struct packed {
        logic           conv;  // 1 = convergent rule
        logic [SHW-1:0] sh;    // log2 of scale
        logic [OVW-1:0] ovl;   // overlap
        logic [OFW-1:0] ofs;   // offset, signed
    } dim_rule_t;

    localparam int RULE_W = $bits(dim_rule_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XDIM,
        ST_YDIM,
        ST_EMIT
    } seq_state_t;
endpackage

// File: rtl/cfu_rule_table.sv
// Rule table: ENTRIES pairs of X/Y rules. It is written one entry per
// cfg_we pulse and read asynchronously by index.
// Assumes: software does not write the entry that a neuron in flight uses.
module cfu_rule_table
    import cfu_pkg::*;
#(
    parameter  int ENTRIES = 32,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [IW-1:0] wr_idx,
    input  dim_rule_t wr_x,
    input  dim_rule_t wr_y,
    input  logic [IW-1:0] rd_idx,
    output dim_rule_t rd_x,
    output dim_rule_t rd_y
);
    dim_rule_t tab_x [ENTRIES];
    dim_rule_t tab_y [ENTRIES];

    // storage: clear on reset, single-entry write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_x[i] <= '0;
                tab_y[i] <= '0;
            end
        end else if (wr_en) begin
            tab_x[wr_idx] <= wr_x;
            tab_y[wr_idx] <= wr_y;
        end
    end

    assign rd_x = tab_x[rd_idx];
    assign rd_y = tab_y[rd_idx];
endmodule

// File: rtl/cfu_coord_decode.sv
// Coordinate decode: splits the sector number and the block number into
// their x and y parts and concatenates them. All counts are powers of two,
// so the multiplies and adds reduce to bit placement.
module cfu_coord_decode #(
    parameter  int SXL = 2,
    parameter  int SYL = 2,
    parameter  int BXL = 3,
    parameter  int BYL = 3,
    localparam int SNW = SXL + SYL,
    localparam int BNW = BXL + BYL
) (
    input  logic [SNW-1:0]     sn,
    input  logic [BNW-1:0]     bn,
    output logic [BXL+SXL-1:0] cx,
    output logic [BYL+SYL-1:0] cy
);
    assign cx = {bn[BXL-1:0],   sn[SXL-1:0]};
    assign cy = {bn[BNW-1:BXL], sn[SNW-1:SXL]};
endmodule

// File: rtl/cfu_field_calc.sv
// Shared field datapath: for one coordinate and one rule, gives the signed
// first and last connected index. The backward flag swaps the rule kind.
// Purely combinational; the caller applies it to X and then to Y.
module cfu_field_calc
    import cfu_pkg::*;
#(
    parameter int CW = 5,
    parameter int FW = 15
) (
    input  logic [CW-1:0]        coord,
    input  dim_rule_t            rule,
    input  logic                 bwd,
    output logic signed [FW-1:0] first,
    output logic signed [FW-1:0] last
);
    logic          conv_eff;
    logic [FW-1:0] cext;
    logic [FW-1:0] base;
    logic [FW-1:0] span;
    logic [FW-1:0] tail;

    // rule kind after direction swap, then scaled centre, spread and tail
    always_comb begin
        conv_eff = rule.conv ^ bwd;
        cext     = FW'(coord);
        base     = conv_eff ? (cext >> rule.sh) : (cext << rule.sh);
        span     = FW'(rule.ovl) + FW'($signed(rule.ofs));
        tail     = conv_eff ? '0 : ((FW'(1) << rule.sh) - FW'(1));
        first    = $signed(base - span);
        last     = $signed(base + span + tail);
    end
endmodule

// File: rtl/conn_field_unit.sv
// Connection field unit (top). It accepts one neuron per input handshake,
// latches it, evaluates X and then Y on the shared field datapath, and
// offers the result until it is taken.
// Assumes: the rule table is not rewritten for an entry in flight.
module conn_field_unit
    import cfu_pkg::*;
#(
    parameter  int SXL     = 2,
    parameter  int SYL     = 2,
    parameter  int BXL     = 3,
    parameter  int BYL     = 3,
    parameter  int ENTRIES = 32,
    localparam int SNW     = SXL + SYL,
    localparam int BNW     = BXL + BYL,
    localparam int XW      = BXL + SXL,
    localparam int YW      = BYL + SYL,
    localparam int CW      = (XW > YW) ? XW : YW,
    localparam int FW      = CW + (1 << SHW) + 2,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [RULE_W-1:0]    cfg_rule_x,
    input  logic [RULE_W-1:0]    cfg_rule_y,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SNW-1:0]       in_sn,
    input  logic [BNW-1:0]       in_bn,
    input  logic [IW-1:0]        in_cn,
    input  logic                 in_bwd,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [XW-1:0]        out_x,
    output logic [YW-1:0]        out_y,
    output logic [IW-1:0]        out_cn,
    output logic signed [FW-1:0] out_first_x,
    output logic signed [FW-1:0] out_last_x,
    output logic signed [FW-1:0] out_first_y,
    output logic signed [FW-1:0] out_last_y
);
    seq_state_t           state;
    logic [SNW-1:0]       hold_sn;
    logic [BNW-1:0]       hold_bn;
    logic [IW-1:0]        hold_cn;
    logic                 hold_bwd;
    logic [XW-1:0]        cx;
    logic [YW-1:0]        cy;
    dim_rule_t            rx;
    dim_rule_t            ry;
    dim_rule_t            act_rule;
    logic [CW-1:0]        act_coord;
    logic signed [FW-1:0] dp_first;
    logic signed [FW-1:0] dp_last;

    cfu_rule_table #(.ENTRIES(ENTRIES)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_x   (dim_rule_t'(cfg_rule_x)),
        .wr_y   (dim_rule_t'(cfg_rule_y)),
        .rd_idx (hold_cn),
        .rd_x   (rx),
        .rd_y   (ry)
    );

    cfu_coord_decode #(.SXL(SXL), .SYL(SYL), .BXL(BXL), .BYL(BYL)) decode_i (
        .sn (hold_sn),
        .bn (hold_bn),
        .cx (cx),
        .cy (cy)
    );

    // one datapath, operands steered by the dimension being worked on
    always_comb begin
        if (state == ST_YDIM) begin
            act_coord = CW'(cy);
            act_rule  = ry;
        end else begin
            act_coord = CW'(cx);
            act_rule  = rx;
        end
    end

    cfu_field_calc #(.CW(CW), .FW(FW)) field_i (
        .coord (act_coord),
        .rule  (act_rule),
        .bwd   (hold_bwd),
        .first (dp_first),
        .last  (dp_last)
    );

    // sequencer: accept, X pass, Y pass, present result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            hold_sn     <= '0;
            hold_bn     <= '0;
            hold_cn     <= '0;
            hold_bwd    <= 1'b0;
            out_first_x <= '0;
            out_last_x  <= '0;
            out_first_y <= '0;
            out_last_y  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) begin
                    hold_sn  <= in_sn;
                    hold_bn  <= in_bn;
                    hold_cn  <= in_cn;
                    hold_bwd <= in_bwd;
                    state    <= ST_XDIM;
                end
                ST_XDIM: begin
                    out_first_x <= dp_first;
                    out_last_x  <= dp_last;
                    state       <= ST_YDIM;
                end
                ST_YDIM: begin
                    out_first_y <= dp_first;
                    out_last_y  <= dp_last;
                    state       <= ST_EMIT;
                end
                ST_EMIT: if (out_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_EMIT);
    assign out_x     = cx;
    assign out_y     = cy;
    assign out_cn    = hold_cn;
endmodule

// File: rtl/cfu_checker.sv
// Protocol checker for conn_field_unit, bound to every instance. It watches
// only the top-level ports.
module cfu_checker #(
    parameter int XW = 5,
    parameter int YW = 5,
    parameter int FW = 15,
    parameter int IW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [IW-1:0]        in_cn,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [XW-1:0]        out_x,
    input logic [YW-1:0]        out_y,
    input logic [IW-1:0]        out_cn,
    input logic signed [FW-1:0] out_first_x,
    input logic signed [FW-1:0] out_last_x,
    input logic signed [FW-1:0] out_first_y,
    input logic signed [FW-1:0] out_last_y
);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##3 out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_x, out_y, out_cn,
            out_first_x, out_last_x, out_first_y, out_last_y})));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    assert_one_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_cn_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_cn == $past(in_cn, 3)));
endmodule

bind conn_field_unit cfu_checker #(.XW(XW), .YW(YW), .FW(FW), .IW(IW)) chk_i (.*);

// File: tb/conn_field_unit_tb_top.sv
// Scoreboard bench: the driver pushes model results into a queue, and the
// monitor pops one per output handshake and compares it with the outputs.
module conn_field_unit_tb_top;
    localparam int SXL = 2, SYL = 2, BXL = 3, BYL = 3, ENT = 32;
    localparam int SNW = SXL + SYL, BNW = BXL + BYL;
    localparam int XW = BXL + SXL, YW = BYL + SYL;
    localparam int CW = (XW > YW) ? XW : YW;
    localparam int FW = CW + 8 + 2;
    localparam int IW = 5;

    typedef struct {
        int x; int y; int cn; int fx; int lx; int fy; int ly;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [19:0] cfg_rule_x = '0, cfg_rule_y = '0;
    logic in_valid = 1'b0, in_bwd = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [SNW-1:0] in_sn = '0;
    logic [BNW-1:0] in_bn = '0;
    logic [IW-1:0] in_cn = '0;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [IW-1:0] out_cn;
    logic signed [FW-1:0] out_first_x, out_last_x, out_first_y, out_last_y;

    int n_checks = 0, n_fails = 0, cyc = 0;
    logic [19:0] shadow_x [ENT];
    logic [19:0] shadow_y [ENT];
    exp_t sb_q[$];

    conn_field_unit dut_i (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic void dim_model(input int c, input logic [19:0] w, input bit bwd,
                                      output int f, output int l);
        int s, ov, of, base;
        bit cv;
        s  = int'(w[18:16]);
        ov = int'(w[15:8]);
        of = int'($signed(w[7:0]));
        cv = w[19] ^ bwd;
        base = cv ? (c / (1 << s)) : (c * (1 << s));
        f = base - ov - of;
        l = base + ov + of + (cv ? 0 : (1 << s) - 1);
    endfunction

    function automatic exp_t model(input int sn, input int bn, input int cn, input bit bwd);
        exp_t e;
        e.x  = (bn % (1 << BXL)) * (1 << SXL) + sn % (1 << SXL);
        e.y  = (bn / (1 << BXL)) * (1 << SYL) + sn / (1 << SXL);
        e.cn = cn;
        dim_model(e.x, shadow_x[cn], bwd, e.fx, e.lx);
        dim_model(e.y, shadow_y[cn], bwd, e.fy, e.ly);
        return e;
    endfunction

    task automatic write_rule(input int idx, input logic [19:0] wx, input logic [19:0] wy);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_rule_x = wx; cfg_rule_y = wy;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_x[idx] = wx;
        shadow_y[idx] = wy;
    endtask

    // rule word: {conv, shift[2:0], overlap[7:0], offset[7:0]}
    function automatic logic [19:0] rw(input bit cv, input int sh, input int ov, input int of);
        return {cv, 3'(sh), 8'(ov), 8'(of)};
    endfunction

    task automatic send(input int sn, input int bn, input int cn, input bit bwd, input bit lat);
        @(negedge clk);
        in_valid = 1'b1; in_sn = SNW'(sn); in_bn = BNW'(bn); in_cn = IW'(cn); in_bwd = bwd;
        while (!in_ready) @(negedge clk);
        sb_q.push_back(model(sn, bn, cn, bwd));
        @(negedge clk);
        in_valid = 1'b0;
        if (lat) begin
            chk(!in_ready, "R9 in_ready low after accept", int'(in_ready), 0);
            chk(!out_valid, "R9 no result one edge after accept", int'(out_valid), 0);
            @(negedge clk);
            chk(!out_valid, "R9 no result two edges after accept", int'(out_valid), 0);
            @(negedge clk);
            chk(out_valid, "R9 result three edges after accept", int'(out_valid), 1);
        end
    endtask

    // monitor: drives out_ready and scores every output handshake
    initial begin
        bit stalled;
        int sv [7];
        stalled = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                out_ready = ((cyc % 5) != 3);
                if (stalled) begin
                    chk(out_valid, "R9 out_valid held under stall", int'(out_valid), 1);
                    chk(sv[0] == int'($signed(out_first_x)) && sv[1] == int'($signed(out_last_x)) &&
                        sv[2] == int'($signed(out_first_y)) && sv[3] == int'($signed(out_last_y)) &&
                        sv[4] == int'(out_x) && sv[5] == int'(out_y) && sv[6] == int'(out_cn),
                        "R9 outputs stable under stall", int'($signed(out_first_x)), sv[0]);
                    stalled = 1'b0;
                end
                if (out_valid && !out_ready) begin
                    sv[0] = int'($signed(out_first_x)); sv[1] = int'($signed(out_last_x));
                    sv[2] = int'($signed(out_first_y)); sv[3] = int'($signed(out_last_y));
                    sv[4] = int'(out_x); sv[5] = int'(out_y); sv[6] = int'(out_cn);
                    stalled = 1'b1;
                end else if (out_valid && out_ready) begin
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected result", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(int'(out_x) == e.x, "R1 out_x", int'(out_x), e.x);
                        chk(int'(out_y) == e.y, "R2 out_y", int'(out_y), e.y);
                        chk(int'(out_cn) == e.cn, "R10 out_cn", int'(out_cn), e.cn);
                        chk(int'($signed(out_first_x)) == e.fx, "R3 R4 R5 R6 R8 first_x",
                            int'($signed(out_first_x)), e.fx);
                        chk(int'($signed(out_last_x)) == e.lx, "R3 R4 R5 R6 R8 last_x",
                            int'($signed(out_last_x)), e.lx);
                        chk(int'($signed(out_first_y)) == e.fy, "R3 R4 R5 R6 R8 first_y",
                            int'($signed(out_first_y)), e.fy);
                        chk(int'($signed(out_last_y)) == e.ly, "R3 R4 R5 R6 R8 last_y",
                            int'($signed(out_last_y)), e.ly);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", sb_q.size());
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // stimulus
    initial begin
        for (int i = 0; i < ENT; i++) begin shadow_x[i] = '0; shadow_y[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!out_valid, "R11 out_valid low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R11 in_ready after reset", int'(in_ready), 1);
        chk(!out_valid, "R11 out_valid after reset", int'(out_valid), 0);

        // R7: never-written entry 3 is all zeros (divergent, scale 1)
        send(5, 9, 3, 1'b0, 1'b1);

        write_rule(0,  rw(0, 1, 1, 0),    rw(0, 1, 1, 0));
        write_rule(5,  rw(1, 2, 1, 1),    rw(1, 1, 0, 0));
        write_rule(9,  rw(0, 0, 0, 0),    rw(1, 2, 2, -1));  // R5 mixed kinds
        write_rule(31, rw(0, 3, 2, -3),   rw(0, 0, 0, 2));
        write_rule(17, rw(0, 2, 3, 1),    rw(1, 3, 1, -2));
        write_rule(18, rw(1, 1, 4, 4),    rw(0, 2, 0, -1));   // R7 neighbour write

        // R8: origin neuron with a wide field gives negative first indices
        send(0, 0, 31, 1'b0, 1'b0);
        send(0, 0, 17, 1'b1, 1'b0);
        // R7: entry 17 is unaffected by the write to 18
        send(6, 20, 17, 1'b0, 1'b0);
        send(15, 63, 18, 1'b0, 1'b0);

        // sweep: forward and backward (R6), several entries, R1 R2 patterns
        for (int i = 0; i < 48; i++) begin
            int cns [6];
            cns = '{0, 5, 9, 31, 17, 18};
            send((i * 7) % 16, (i * 13 + 3) % 64, cns[i % 6], bit'((i / 6) % 2), 1'b0);
        end

        wait (sb_q.size() == 0);
        repeat (6) @(negedge clk);
        chk(in_ready && !out_valid, "R9 idle at end", int'(out_valid), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule